// File: doc/BRIEF.md
# Debug Forward Relay

This block sits inside a processor core and lets an I/O bridge that has no wiring of its own to the level-2 cache banks reach them anyway. The bridge puts a forward-request packet on the core's inbound channel. The relay captures it and sends it out again on the core's outbound request channel, steered to the L2 bank that the address bits in the payload select. The bank answers with a forward-reply on the inbound channel. The relay captures that reply and sends it outbound to the I/O bridge's destination.

Only one relay transaction is in flight at any time. While one is in flight, a new forward-request is refused. A reply that shows up when none is expected is discarded, and a one-cycle error pulse reports it. On the outbound channel, relayed packets are granted ahead of the core's own load and store traffic. A core request that spans several beats is never interrupted, though: once its first beat has gone out, the remaining beats go first.

Packet kinds are 2-bit codes: 0 is a load, 1 is a store, 2 is a forward-request and 3 is a forward-reply.

Top module: `dbg_fwd_relay`

## Requirements
- R1: When the relay is idle, an inbound packet of kind 2 is accepted. In the next cycle the outbound port presents kind 2 with the payload unchanged.
- R2: The destination of a relayed forward-request is the L2 bank number taken from payload bits [7:6] (four banks), zero-extended to the 3-bit destination field.
- R3: A kind 3 packet that arrives while a reply is awaited is accepted. In the next cycle it is presented outbound as kind 3 with destination 7 and the payload unchanged. Once it has been sent, the relay is idle again.
- R4: While a relay transaction is outstanding, a kind 2 packet offered inbound sees in_ready low, is not taken, and produces no output.
- R5: While a relayed packet is pending and no core multi-beat request is open, the outbound port carries the relayed packet and core_ready is low, even if the core is offering a packet.
- R6: A kind 3 packet that arrives when no reply is awaited produces no outbound packet. It raises err_orphan for exactly the next cycle.
- R7: After a core beat with core_last low has been accepted, the core's remaining beats are sent before any relayed packet.
- R8: While a relayed packet is presented and out_ready is low, out_valid stays high and the kind, destination and payload stay unchanged.
- R9: Inbound packets of kind 0 or 1 are accepted (in_ready high) and have no effect: no output and no error.
- R10: During and after reset, out_valid and err_orphan are low and in_ready is high, as long as the core offers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound packet valid |
| in_ready | output | 1 | Inbound packet accepted |
| in_kind | input | 2 | Inbound packet kind |
| in_data | input | 32 | Inbound payload |
| core_valid | input | 1 | Core request beat valid |
| core_ready | output | 1 | Core beat accepted |
| core_kind | input | 2 | Core beat kind |
| core_dest | input | 3 | Core beat destination |
| core_data | input | 32 | Core beat payload |
| core_last | input | 1 | Final beat of a core request |
| out_valid | output | 1 | Outbound packet valid |
| out_ready | input | 1 | Outbound channel accepts |
| out_kind | output | 2 | Outbound packet kind |
| out_dest | output | 3 | Outbound destination |
| out_data | output | 32 | Outbound payload |
| err_orphan | output | 1 | Unexpected reply dropped (one-cycle pulse) |

## Verification
A forward-request or forward-reply accepted at a clock edge appears on the outbound port directly after that edge, one register later, and an orphan reply raises err_orphan in that same following cycle. The bench drives inputs just after a rising edge and reads every result at the next falling edge. At that falling edge it checks the one-cycle latency directly. A scoreboard queue holds the expected outbound packets in their required order, and each transfer is compared on the falling edge at which out_valid and out_ready are both high. Refusals, pulses and stalls are checked at the falling edges of the cycles concerned.

// File: rtl/dbg_relay_pkg.sv
package dbg_relay_pkg;
  localparam logic [1:0] K_LOAD  = 2'd0;
  localparam logic [1:0] K_STORE = 2'd1;
  localparam logic [1:0] K_FREQ  = 2'd2;
  localparam logic [1:0] K_FRPL  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RPL  = 2'd3
  } relay_st_e;
endpackage

// File: rtl/dbg_relay_rst_sync.sv
module dbg_relay_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dbg_relay_bank_sel.sv
module dbg_relay_bank_sel #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned DESTW = 3,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [BW-1:0]    sel_bits,
  output logic [DESTW-1:0] bank_dest
);
  generate
    if (NBANK > 1) begin : g_multi
      assign bank_dest = DESTW'(sel_bits);
    end else begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_bits;
      assign bank_dest  = '0;
    end
  endgenerate
endmodule

// File: rtl/dbg_relay_ctrl.sv
module dbg_relay_ctrl
  import dbg_relay_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned DESTW    = 3,
  parameter int unsigned IOB_DEST = 7
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic [DW-1:0]    in_data,
  input  logic [DESTW-1:0] bank_dest,
  input  logic             rly_go,
  output logic             in_ready,
  output logic             rly_vld,
  output logic [1:0]       rly_kind,
  output logic [DESTW-1:0] rly_dest,
  output logic [DW-1:0]    rly_data,
  output logic             err_orphan
);
  relay_st_e        st_q, st_d;
  logic             acc_req, acc_rpl, orphan;
  logic             hold_en;
  logic [1:0]       kind_d, kind_q;
  logic [DESTW-1:0] dest_d, dest_q;
  logic [DW-1:0]    data_q;
  logic             err_q;

  assign acc_req = in_valid && (in_kind == K_FREQ) && (st_q == ST_IDLE);
  assign acc_rpl = in_valid && (in_kind == K_FRPL) && (st_q == ST_WAIT);
  assign orphan  = in_valid && (in_kind == K_FRPL) && (st_q != ST_WAIT);
  assign hold_en = acc_req || acc_rpl;

  assign in_ready = (in_kind != K_FREQ) || (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    kind_d = K_FREQ;
    dest_d = bank_dest;
    case (st_q)
      ST_IDLE: if (acc_req) st_d = ST_REQ;
      ST_REQ:  if (rly_go)  st_d = ST_WAIT;
      ST_WAIT: if (acc_rpl) begin
        st_d   = ST_RPL;
        kind_d = K_FRPL;
        dest_d = DESTW'(IOB_DEST);
      end
      ST_RPL:  if (rly_go)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= orphan;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      kind_q <= kind_d;
      dest_q <= dest_d;
      data_q <= in_data;
    end
  end

  assign rly_vld    = (st_q == ST_REQ) || (st_q == ST_RPL);
  assign rly_kind   = kind_q;
  assign rly_dest   = dest_q;
  assign rly_data   = data_q;
  assign err_orphan = err_q;

  a_r1_req_captured: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_req |=> (rly_vld && rly_kind == K_FREQ));
  a_r3_back_to_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_RPL && rly_go) |=> in_ready);
  a_r6_orphan_flag: assert property (@(posedge clk) disable iff (!rst_sn)
    orphan |=> (err_orphan && !(hold_en && $past(st_q) != ST_WAIT && st_q == ST_RPL)));
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_sn)
    (rly_vld && !rly_go) |=> (rly_vld && $stable(rly_data) && $stable(rly_dest) && $stable(rly_kind)));
endmodule

// File: rtl/dbg_relay_arb.sv
module dbg_relay_arb (
  input  logic clk,
  input  logic rst_sn,
  input  logic rly_vld,
  input  logic core_valid,
  input  logic core_last,
  input  logic out_ready,
  output logic sel_rly,
  output logic rly_go,
  output logic core_ready
);
  logic busy_q, busy_d;
  logic core_fire;

  assign sel_rly    = rly_vld && !busy_q;
  assign rly_go     = sel_rly && out_ready;
  assign core_ready = out_ready && !sel_rly;
  assign core_fire  = core_valid && core_ready;

  always_comb begin
    busy_d = busy_q;
    if (core_fire) busy_d = !core_last;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  a_r7_no_split: assert property (@(posedge clk) disable iff (!rst_sn)
    (core_fire && !core_last) |=> !rly_go);
  a_r5_relay_first: assert property (@(posedge clk) disable iff (!rst_sn)
    (rly_vld && !busy_q && core_valid) |-> !core_fire);
endmodule

// File: rtl/dbg_fwd_relay.sv
module dbg_fwd_relay
  import dbg_relay_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned DESTW    = 3,
  parameter int unsigned NBANK    = 4,
  parameter int unsigned BANK_LSB = 6,
  parameter int unsigned IOB_DEST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [DW-1:0]    in_data,
  input  logic             core_valid,
  output logic             core_ready,
  input  logic [1:0]       core_kind,
  input  logic [DESTW-1:0] core_dest,
  input  logic [DW-1:0]    core_data,
  input  logic             core_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [DESTW-1:0] out_dest,
  output logic [DW-1:0]    out_data,
  output logic             err_orphan
);
  localparam int unsigned BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic             rst_sn;
  logic [DESTW-1:0] bank_dest;
  logic             rly_vld, rly_go, sel_rly;
  logic [1:0]       rly_kind;
  logic [DESTW-1:0] rly_dest;
  logic [DW-1:0]    rly_data;

  dbg_relay_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  dbg_relay_bank_sel #(.NBANK(NBANK), .DESTW(DESTW)) u_bank (
    .sel_bits  (in_data[BANK_LSB +: BW]),
    .bank_dest (bank_dest)
  );

  dbg_relay_ctrl #(.DW(DW), .DESTW(DESTW), .IOB_DEST(IOB_DEST)) u_ctrl (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .in_valid   (in_valid),
    .in_kind    (in_kind),
    .in_data    (in_data),
    .bank_dest  (bank_dest),
    .rly_go     (rly_go),
    .in_ready   (in_ready),
    .rly_vld    (rly_vld),
    .rly_kind   (rly_kind),
    .rly_dest   (rly_dest),
    .rly_data   (rly_data),
    .err_orphan (err_orphan)
  );

  dbg_relay_arb u_arb (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .rly_vld    (rly_vld),
    .core_valid (core_valid),
    .core_last  (core_last),
    .out_ready  (out_ready),
    .sel_rly    (sel_rly),
    .rly_go     (rly_go),
    .core_ready (core_ready)
  );

  assign out_valid = sel_rly || core_valid;
  assign out_kind  = sel_rly ? rly_kind : core_kind;
  assign out_dest  = sel_rly ? rly_dest : core_dest;
  assign out_data  = sel_rly ? rly_data : core_data;

  a_r9_ignore_normal: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && (in_kind == K_LOAD || in_kind == K_STORE)) |-> in_ready);
  a_r10_quiet_reset: assert property (@(posedge clk)
    (!rst_sn && !core_valid) |-> (!out_valid && in_ready));
endmodule

// File: tb/dbg_fwd_relay_tb.sv
module dbg_fwd_relay_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [1:0]  in_kind;
  logic [31:0] in_data;
  logic        core_valid, core_ready, core_last;
  logic [1:0]  core_kind;
  logic [2:0]  core_dest;
  logic [31:0] core_data;
  logic        out_valid, out_ready;
  logic [1:0]  out_kind;
  logic [2:0]  out_dest;
  logic [31:0] out_data;
  logic        err_orphan;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [36:0] exp_q[$];

  always #4 clk = ~clk;

  dbg_fwd_relay u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .core_valid(core_valid), .core_ready(core_ready), .core_kind(core_kind),
    .core_dest(core_dest), .core_data(core_data), .core_last(core_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dest(out_dest), .out_data(out_data), .err_orphan(err_orphan)
  );

  function automatic logic [2:0] bank_of(input logic [31:0] d);
    return {1'b0, d[7:6]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] k, input logic [2:0] d, input logic [31:0] v);
    exp_q.push_back({k, d, v});
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R3/R5/R7 unexpected packet", {27'd0, out_kind, out_dest, out_data}, 64'd0);
      end else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        check({out_kind, out_dest, out_data} == e, "R1/R2/R3/R5/R7 outbound packet",
              {27'd0, out_kind, out_dest, out_data}, {27'd0, e});
      end
    end
  end

  task automatic inb(input logic [1:0] k, input logic [31:0] d);
    in_valid = 1'b1; in_kind = k; in_data = d;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic core_beat(input logic [1:0] k, input logic [2:0] dst, input logic [31:0] d, input logic lst);
    bit acc;
    core_valid = 1'b1; core_kind = k; core_dest = dst; core_data = d; core_last = lst;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = core_ready;
      tick();
    end
    core_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) tick();
    check(exp_q.size() == 0, "R1/R3 expected packets delivered", exp_q.size(), 0);
  endtask

  task automatic relay_round(input logic [31:0] d, input logic [31:0] r);
    push_exp(2'd2, bank_of(d), d);
    inb(2'd2, d);
    @(negedge clk);
    check(out_valid && out_kind == 2'd2, "R1 request one cycle after accept", {out_valid, out_kind}, 3'b110);
    tick();
    push_exp(2'd3, 3'd7, r);
    inb(2'd3, r);
    @(negedge clk);
    check(out_valid && out_kind == 2'd3 && out_dest == 3'd7, "R3 reply one cycle after accept",
          {out_valid, out_kind, out_dest}, 6'b111111);
    tick();
    drain();
  endtask

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'd0; in_data = '0;
    core_valid = 1'b0; core_kind = 2'd0; core_dest = '0; core_data = '0; core_last = 1'b1;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready && !err_orphan, "R10 reset state", {out_valid, in_ready, err_orphan}, 3'b010);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    check(!out_valid && in_ready && !err_orphan, "R10 after reset", {out_valid, in_ready, err_orphan}, 3'b010);
    tick();

    // R1 R2 R3: several payloads, banks 3,1,2,0
    relay_round(32'h0000_00C0, 32'hDEAD_0001);
    relay_round(32'h0000_0040, 32'hDEAD_0002);
    relay_round(32'hA5A5_A5A5, 32'h5A5A_5A5A);
    relay_round(32'h1234_5600, 32'h0BAD_F00D);

    // R4: second request refused while outstanding
    push_exp(2'd2, bank_of(32'h80), 32'h80);
    inb(2'd2, 32'h80);
    tick(); tick();
    in_valid = 1'b1; in_kind = 2'd2; in_data = 32'hC0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!in_ready && !out_valid, "R4 request refused while outstanding", {in_ready, out_valid}, 2'b00);
      tick();
    end
    in_valid = 1'b0;
    push_exp(2'd3, 3'd7, 32'h77);
    inb(2'd3, 32'h77);
    tick();
    drain();

    // R6: orphan reply
    inb(2'd3, 32'h99);
    @(negedge clk);
    check(err_orphan && !out_valid, "R6 orphan flagged and dropped", {err_orphan, out_valid}, 2'b10);
    tick();
    @(negedge clk);
    check(!err_orphan && !out_valid, "R6 pulse lasts one cycle", {err_orphan, out_valid}, 2'b00);
    tick();

    // R9: normal inbound kinds ignored
    in_valid = 1'b1; in_kind = 2'd0; in_data = 32'h40;
    @(negedge clk);
    check(in_ready, "R9 load response accepted", in_ready, 1);
    tick();
    in_kind = 2'd1;
    @(negedge clk);
    check(in_ready && !out_valid, "R9 store response accepted", {in_ready, out_valid}, 2'b10);
    tick();
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid && !err_orphan && in_ready, "R9 no effect", {out_valid, err_orphan, in_ready}, 3'b001);
    tick();

    // R5 + R8: relay wins over a waiting core packet, stable while stalled
    out_ready = 1'b0;
    core_valid = 1'b1; core_kind = 2'd0; core_dest = 3'd2; core_data = 32'h11; core_last = 1'b1;
    push_exp(2'd2, bank_of(32'hC0), 32'hC0);
    push_exp(2'd0, 3'd2, 32'h11);
    inb(2'd2, 32'hC0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && out_kind == 2'd2 && out_dest == 3'd3 && out_data == 32'hC0 && !core_ready,
            "R5 R8 relay presented and held", {out_valid, out_kind, out_dest, out_data, core_ready},
            {1'b1, 2'd2, 3'd3, 32'hC0, 1'b0});
      tick();
    end
    out_ready = 1'b1;
    core_beat(2'd0, 3'd2, 32'h11, 1'b1);
    push_exp(2'd3, 3'd7, 32'h33);
    inb(2'd3, 32'h33);
    tick();
    drain();

    // R7: multi-beat core request is not split
    core_valid = 1'b1; core_kind = 2'd1; core_dest = 3'd1; core_data = 32'hB1; core_last = 1'b0;
    push_exp(2'd1, 3'd1, 32'hB1);
    push_exp(2'd1, 3'd1, 32'hB2);
    push_exp(2'd2, bank_of(32'h40), 32'h40);
    in_valid = 1'b1; in_kind = 2'd2; in_data = 32'h40;
    @(negedge clk);
    check(core_ready, "R7 first beat taken", core_ready, 1);
    tick();
    in_valid = 1'b0;
    core_data = 32'hB2; core_last = 1'b1;
    @(negedge clk);
    check(out_valid && out_kind == 2'd1 && out_data == 32'hB2 && core_ready, "R7 second beat before relay",
          {out_kind, out_data}, {2'd1, 32'hB2});
    tick();
    core_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_kind == 2'd2, "R7 relay follows last beat", out_kind, 2'd2);
    tick();
    push_exp(2'd3, 3'd7, 32'h44);
    inb(2'd3, 32'h44);
    tick();
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule